// File: doc/BRIEF.md
# Qualified Valley Pulse Detector

This block times the turn-on of the power switch in a quasi-resonant flyback converter. Two comparators on the auxiliary-winding sense node deliver digital flags. The upper flag (arm) goes high above a higher threshold. The lower flag (trip) goes high above a lower threshold. The gate-drive state comes in as a third input. The detector accepts a falling trip edge only under two conditions. First, an arm crossing must have come before it. Second, the edge must lie outside a blanking window that opens when the gate turns off. Each accepted edge then produces a one-cycle valley pulse after a fixed delay.

All three inputs pass through a two-stage synchronizer and a run-length glitch filter. Edges are found only after that. Feeding the gate through the same path puts the mask window and the crossings on a single time base. The mask length, the pulse delay and the filter length are parameters given in clock cycles. The arm state is cleared at every falling trip edge, accepted or not, so each valley needs a fresh arm crossing.

Top module: `valley_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `valley_o` and `armed_o` are 0.
- R2: If `arm_flag_i` is first sampled high at clock edge a and stays high for at least FILT_LEN samples, `armed_o` is 1 after edge a+4 (default FILT_LEN=2, two sync stages).
- R3: Suppose the detector is armed and `trip_flag_i` is first sampled low at edge t, more than MASK_CYC edges after `gate_i` was first sampled low. Then `valley_o` is high for the cycle after edge t+4+DELAY_CYC.
- R4: A falling trip edge while `armed_o` is 0 produces no pulse.
- R5: Let d be the number of edges from the first low sample of `gate_i` to the first low sample of `trip_flag_i`. A falling trip edge with d <= MASK_CYC is discarded and produces no pulse.
- R6: A falling trip edge while the conditioned gate level is high (switch on) is discarded.
- R7: Every falling trip edge clears the arm state, so `armed_o` is 0 after edge t+4, whether the edge was accepted or discarded.
- R8: A level on any flag that lasts fewer than FILT_LEN consecutive samples is ignored. A one-sample arm pulse does not arm. A one-sample trip dip neither clears the arm state nor produces a pulse.
- R9: An accepted edge that arrives while an earlier pulse is still pending restarts the delay. Only the later pulse is emitted, at its own t+4+DELAY_CYC.
- R10: `valley_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_flag_i | input | 1 | High while the sense voltage is above the upper (arm) threshold |
| trip_flag_i | input | 1 | High while the sense voltage is above the lower (trip) threshold |
| gate_i | input | 1 | Gate-drive state, high while the switch is on |
| valley_o | output | 1 | One-cycle valley pulse, registered |
| armed_o | output | 1 | Arm state, registered |

## Verification
Every result has a fixed distance from the clock edge that first sampled its cause. `armed_o` rises four edges after the arm flag's first high sample and falls four edges after the trip flag's first low sample. `valley_o` is high after edge t+4+DELAY_CYC. The mask distance d is counted between the first low samples of gate and trip. For each crossing the bench records the index of the edge that sampled the change, computes the due cycle and queues it. The monitor compares each pulse against the head of the queue at the falling clock edge. Arm-state checks are made several cycles after their due edge, never on it.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  // Bit positions of the flags inside the conditioned vector.
  typedef enum int {
    FLAG_ARM  = 0,
    FLAG_TRIP = 1,
    FLAG_GATE = 2
  } flag_idx_e;

  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/vpd_conditioner.sv
// Synchronizer plus run-length glitch filter, one lane per flag.
module vpd_conditioner #(
  parameter int WIDTH       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] clean_o
);
  localparam int RUN_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    logic [SYNC_STAGES-1:0] sync_q;
    logic [RUN_W-1:0]       run_q;
    logic                   level_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q  <= '0;
        run_q   <= '0;
        level_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i[b]};
        if (synced == level_q) begin
          run_q <= '0;
        end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
          level_q <= synced;
          run_q   <= '0;
        end else begin
          run_q <= run_q + RUN_W'(1);
        end
      end
    end

    assign clean_o[b] = level_q;
  end
endmodule

// File: rtl/vpd_mask_timer.sv
// Blanking window opened by a gate turn-off event.
module vpd_mask_timer #(
  parameter int MASK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(MASK_CYC + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (start_i) begin
      left_q <= CW'(MASK_CYC);
    end else if (left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  assign active_o = start_i | (left_q != '0);
endmodule

// File: rtl/vpd_delay.sv
// Fixed delay from an accepted crossing to the registered pulse; a new start restarts it.
module vpd_delay #(
  parameter int DELAY_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic pulse_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (start_i) begin
        cnt_q  <= CW'(DELAY_CYC);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q == CW'(1)) begin
          pulse_q <= 1'b1;
          busy_q  <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/valley_detector.sv
module valley_detector
  import vpd_pkg::*;
#(
  parameter int DELAY_CYC   = 50,
  parameter int MASK_CYC    = 200,
  parameter int FILT_LEN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_flag_i,
  input  logic trip_flag_i,
  input  logic gate_i,
  output logic valley_o,
  output logic armed_o
);
  logic [NUM_FLAGS-1:0] raw;
  logic [NUM_FLAGS-1:0] clean;
  logic [NUM_FLAGS-1:0] clean_q;

  always_comb begin
    raw            = '0;
    raw[FLAG_ARM]  = arm_flag_i;
    raw[FLAG_TRIP] = trip_flag_i;
    raw[FLAG_GATE] = gate_i;
  end

  vpd_conditioner #(
    .WIDTH      (NUM_FLAGS),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) i_cond (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw),
    .clean_o(clean)
  );

  always_ff @(posedge clk) begin
    if (rst) clean_q <= '0;
    else     clean_q <= clean;
  end

  logic arm_rise;
  logic trip_fall;
  logic gate_fall;
  logic gate_lvl;

  assign arm_rise  =  clean[FLAG_ARM]  & ~clean_q[FLAG_ARM];
  assign trip_fall = ~clean[FLAG_TRIP] &  clean_q[FLAG_TRIP];
  assign gate_fall = ~clean[FLAG_GATE] &  clean_q[FLAG_GATE];
  assign gate_lvl  =  clean[FLAG_GATE];

  logic mask_active;

  vpd_mask_timer #(.MASK_CYC(MASK_CYC)) i_mask (
    .clk     (clk),
    .rst     (rst),
    .start_i (gate_fall),
    .active_o(mask_active)
  );

  // Arm state: set by a rising arm edge, cleared by any falling trip edge.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst)            armed_q <= 1'b0;
    else if (trip_fall) armed_q <= 1'b0;
    else if (arm_rise)  armed_q <= 1'b1;
  end

  logic accept;
  assign accept = trip_fall & armed_q & ~gate_lvl & ~mask_active;

  logic dly_busy;
  logic dly_pulse;

  vpd_delay #(.DELAY_CYC(DELAY_CYC)) i_dly (
    .clk    (clk),
    .rst    (rst),
    .start_i(accept),
    .busy_o (dly_busy),
    .pulse_o(dly_pulse)
  );

  assign valley_o = dly_pulse;
  assign armed_o  = armed_q;
endmodule

// File: rtl/vpd_checker.sv
module vpd_checker #(
  parameter int MASK_CYC = 200
) (
  input logic clk,
  input logic rst,
  input logic valley_o,
  input logic armed_o,
  input logic arm_rise,
  input logic trip_fall,
  input logic gate_lvl,
  input logic dly_busy
);
  localparam int CW = $clog2(MASK_CYC + 2);

  // Independent window tracker: edges since the last conditioned gate fall.
  logic          gate_d;
  logic [CW-1:0] since_q;
  logic          gfall;
  logic          in_window;

  assign gfall     = gate_d & ~gate_lvl;
  assign in_window = gfall | (since_q < CW'(MASK_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d  <= 1'b0;
      since_q <= CW'(MASK_CYC);
    end else begin
      gate_d <= gate_lvl;
      if (gfall)                        since_q <= '0;
      else if (since_q < CW'(MASK_CYC)) since_q <= since_q + CW'(1);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!valley_o && !armed_o)); // R1
  AST_ARM_FROM_EDGE: assert property (@(posedge clk) disable iff (rst) $rose(armed_o) |-> $past(arm_rise)); // R2
  AST_PULSE_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst) valley_o |-> $past(dly_busy)); // R3
  AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (rst) (trip_fall && !armed_o && !dly_busy) |=> !dly_busy); // R4
  AST_MASK_DISCARD: assert property (@(posedge clk) disable iff (rst) (trip_fall && in_window && !dly_busy) |=> !dly_busy); // R5
  AST_GATE_ON_DISCARD: assert property (@(posedge clk) disable iff (rst) (trip_fall && gate_lvl && !dly_busy) |=> !dly_busy); // R6
  AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (rst) trip_fall |=> !armed_o); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) valley_o |=> !valley_o); // R10
endmodule

bind valley_detector vpd_checker #(.MASK_CYC(MASK_CYC)) i_vpd_checker (
  .clk      (clk),
  .rst      (rst),
  .valley_o (valley_o),
  .armed_o  (armed_o),
  .arm_rise (arm_rise),
  .trip_fall(trip_fall),
  .gate_lvl (gate_lvl),
  .dly_busy (dly_busy)
);

// File: tb/test_valley_detector.sv
`timescale 1ns/1ps
module test_valley_detector;
  localparam int DLY = 50;
  localparam int MSK = 200;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic trip = 1'b0;
  logic gate = 1'b0;
  logic valley_o;
  logic armed_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;
  int exp_q[$];
  logic prev_v = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  valley_detector #(.DELAY_CYC(DLY), .MASK_CYC(MSK), .FILT_LEN(2), .SYNC_STAGES(2)) i_valley_detector (
    .clk(clk), .rst(rst), .arm_flag_i(arm), .trip_flag_i(trip), .gate_i(gate),
    .valley_o(valley_o), .armed_o(armed_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pop the due cycle of each pulse and compare.
  always @(negedge clk) begin
    if (!rst) begin
      if (valley_o && prev_v) chk("R10 pulse width", 2, 1);
      if (valley_o) begin
        if (exp_q.size() == 0) chk("R3/R4/R5/R6/R9 unexpected pulse", cyc, -1);
        else chk("R3 pulse cycle", cyc, exp_q.pop_front());
      end
    end
    prev_v <= valley_o;
  end

  // Driver for one switching period.
  task automatic period(int rise_at, int arm_len, int fall_at, bit trip_glitch,
                        bit exp_arm, bit exp_pulse, string tag);
    int g, t, used;
    @(negedge clk) gate = 1'b1;
    repeat (20) @(negedge clk);
    gate = 1'b0; g = cyc + 1;
    repeat (rise_at) @(negedge clk);
    trip = 1'b1; arm = (arm_len > 0);
    repeat (arm_len) @(negedge clk);
    arm = 1'b0;
    repeat (8) @(negedge clk);
    chk({tag, " R2/R8 armed"}, armed_o, exp_arm);
    used = rise_at + arm_len + 8;
    if (trip_glitch) begin
      trip = 1'b0;
      @(negedge clk) trip = 1'b1;
      repeat (8) @(negedge clk);
      chk({tag, " R8 dip kept arm"}, armed_o, exp_arm);
      used += 9;
    end
    repeat (fall_at - used) @(negedge clk);
    trip = 1'b0; t = cyc + 1;
    chk({tag, " distance"}, t - g, fall_at);
    if (exp_pulse) exp_q.push_back(t + LAT + DLY);
    repeat (6) @(negedge clk);
    chk({tag, " R7 arm cleared"}, armed_o, 0);
    repeat (DLY + 10) @(negedge clk);
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 valley in reset", valley_o, 0);
    chk("R1 armed in reset", armed_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valley after reset", valley_o, 0);
    chk("R1 armed after reset", armed_o, 0);

    period(100, 10, 300, 0, 1, 1, "R3 accepted");
    period(100, 0, 300, 0, 0, 0, "R4 unarmed");
    period(100, 10, MSK, 0, 1, 0, "R5 mask boundary");
    period(100, 10, MSK + 1, 0, 1, 1, "R5 first outside mask");
    period(50, 10, 150, 0, 1, 0, "R5 inside mask");
    period(100, 1, 300, 0, 0, 0, "R8 arm glitch");
    period(100, 10, 300, 1, 1, 1, "R8 trip dip");

    // R6: falling trip while the switch is on.
    begin
      repeat (MSK + 20) @(negedge clk);
      trip = 1'b1; arm = 1'b1;
      repeat (10) @(negedge clk);
      arm = 1'b0;
      repeat (8) @(negedge clk);
      chk("R6 armed before gate", armed_o, 1);
      gate = 1'b1;
      repeat (6) @(negedge clk);
      trip = 1'b0;
      repeat (8) @(negedge clk);
      chk("R6/R7 arm cleared", armed_o, 0);
      repeat (DLY + 10) @(negedge clk);
      chk("R6 no pulse", exp_q.size(), 0);
      gate = 1'b0;
    end

    // R9: second accepted crossing inside the pending delay.
    begin
      int t2;
      repeat (MSK + 20) @(negedge clk);
      trip = 1'b1; arm = 1'b1;
      repeat (3) @(negedge clk);
      arm = 1'b0;
      repeat (3) @(negedge clk);
      trip = 1'b0;
      repeat (4) @(negedge clk);
      trip = 1'b1; arm = 1'b1;
      repeat (3) @(negedge clk);
      arm = 1'b0;
      repeat (3) @(negedge clk);
      trip = 1'b0; t2 = cyc + 1;
      exp_q.push_back(t2 + LAT + DLY);
      repeat (DLY + 20) @(negedge clk);
      chk("R9 single late pulse", exp_q.size(), 0);
    end

    chk("R10 end queue", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule